// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block supplies the bit-timing strobes for an I2C master. A 3-bit rate code picks one of seven fixed divisors of the system clock, or an external slow clock whose rising edges are counted in groups of eight. Two single-cycle strobes come out. `half_tick` fires at twice the SCL rate, so the bit engine can toggle SCL with equal high and low phases. `scl_en` fires once per full SCL period.

When the rate code is 111, the external clock passes through a flop synchronizer and then a rising-edge detector. Each detected edge advances the same divider counter that the system-clock rates use. Any change of the rate code restarts the divider from zero, so a shortened period never appears. Driving the enable low holds the generator in reset, and raising it again starts a fresh period.

Top module: `scl_rate_gen`

## Requirements
- R1: With rate code 000, 001, 010 or 011, `half_tick` pulses every 128, 112, 96 or 80 system clock cycles, giving SCL at the system clock divided by 256, 224, 192 or 160.
- R2: With rate code 100, 101 or 110, `half_tick` pulses every 480, 60 or 30 system clock cycles, giving SCL at the system clock divided by 960, 120 or 60.
- R3: With rate code 111, `half_tick` pulses once per 4 synchronized rising edges of `ext_clk`, and `scl_en` once per 8. For an external clock running at most at half the system clock rate, the spacing between pulses is exactly 4 external periods.
- R4: `scl_en` is high only in a cycle where `half_tick` is high. It marks the 2nd, 4th, 6th and later half ticks counted from a restart, so its period is twice the half-tick period.
- R5: When a new rate code is sampled at a clock edge, the divider restarts. The first `half_tick` comes exactly one full half period (H cycles) after that edge, and no pulse appears in between.
- R6: While `enable` is 0, both strobes stay 0 from the next clock edge on. The first edge sampled with `enable` at 1 counts as a restart, as in R5.
- R7: During `rst_n` low, both strobes are 0. After release with `enable` high and code 000, the first `half_tick` comes 128 cycles after the first clock edge.
- R8: In the system-clock rates (codes 000 to 110), activity on `ext_clk` has no effect on the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; 0 holds it cleared |
| rate_code | input | 3 | SCL rate selection code |
| ext_clk | input | 1 | External slow clock, asynchronous |
| half_tick | output | 1 | One-cycle pulse at twice the SCL rate |
| scl_en | output | 1 | One-cycle pulse once per SCL period |

## Verification
The bench steps through every rate code and checks the first pulse after each restart against H. A divider that did not restart on a code change would give a short first period. An off-by-one in the wrap compare would stretch or shorten every interval. The bench also checks the spacing of later pulses and the alternation of `scl_en`. A phase register that did not restart would put `scl_en` on odd ticks. In external mode the spacing must equal four external periods exactly, so counting both edges or skipping the synchronizer edge detector shows up as a halved or irregular interval. Toggling the enable checks that nothing leaks through while it is low and that re-enabling starts a clean full period.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

   localparam int unsigned MAX_SYS_DIV = 960;

   typedef enum logic [2:0] {
      RATE_D256 = 3'b000,
      RATE_D224 = 3'b001,
      RATE_D192 = 3'b010,
      RATE_D160 = 3'b011,
      RATE_D960 = 3'b100,
      RATE_D120 = 3'b101,
      RATE_D60  = 3'b110,
      RATE_EXT  = 3'b111
   } rate_sel_e;

   // Full SCL-period divisor for the system-clock codes.
   function automatic int unsigned sys_divisor(input logic [2:0] code);
      case (code)
         RATE_D256: return 256;
         RATE_D224: return 224;
         RATE_D192: return 192;
         RATE_D160: return 160;
         RATE_D960: return 960;
         RATE_D120: return 120;
         RATE_D60:  return 60;
         default:   return 256;
      endcase
   endfunction

endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic async_in,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scl_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sync_q[gi] <= 1'b0;
            else if (clr) sync_q[gi] <= 1'b0;
            else if (gi == 0) sync_q[gi] <= async_in;
            else          sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= 1'b0;
      else if (clr) prev_q <= 1'b0;
      else          prev_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

   // R3: a detected edge is a single-cycle event
   a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/scl_div_counter.sv
module scl_div_counter #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         adv,
   input  logic [W-1:0] limit,
   output logic         tick
);

   generate
      if (W < 2) begin : g_bad_width
         $error("scl_div_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic         wrap;

   assign wrap = adv && (cnt_q == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= wrap;
         if (wrap)     cnt_q <= '0;
         else if (adv) cnt_q <= cnt_q + W'(1);
      end
   end

   // R5: the count never passes the selected half period
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit);

   // R1: a tick only follows an advance from the last count
   a_r1_tick_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(adv && !restart && (cnt_q == limit - W'(1))));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import scl_rate_pkg::*;
#(
   parameter int unsigned EXT_DIV     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [2:0] rate_code,
   input  logic       ext_clk,
   output logic       half_tick,
   output logic       scl_en
);

   localparam int unsigned HALF_EXT = EXT_DIV / 2;
   localparam int unsigned HALF_SYS = MAX_SYS_DIV / 2;
   localparam int unsigned MAX_HALF = (HALF_SYS > HALF_EXT) ? HALF_SYS : HALF_EXT;
   localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

   generate
      if ((EXT_DIV < 2) || (EXT_DIV % 2 != 0)) begin : g_bad_ext_div
         $error("scl_rate_gen: EXT_DIV must be even and at least 2");
      end
   endgenerate

   logic             en_q;
   logic [2:0]       code_q;
   logic             restart;
   logic             ext_mode;
   logic             ext_rise;
   logic             adv;
   logic [CNT_W-1:0] limit;
   logic             tick;
   logic             phase_q;

   // Enable and selected code, sampled so a change is seen as a restart.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         code_q <= RATE_D256;
      end else begin
         en_q   <= enable;
         code_q <= rate_code;
      end
   end

   assign restart  = !enable || !en_q || (rate_code != code_q);
   assign ext_mode = (code_q == RATE_EXT);

   scl_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!enable),
      .async_in (ext_clk),
      .rise     (ext_rise)
   );

   always_comb begin
      if (ext_mode) begin
         limit = CNT_W'(HALF_EXT);
         adv   = ext_rise;
      end else begin
         limit = CNT_W'(sys_divisor(code_q) / 2);
         adv   = 1'b1;
      end
   end

   scl_div_counter #(
      .W (CNT_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .adv     (adv),
      .limit   (limit),
      .tick    (tick)
   );

   // Phase of the SCL period: the second half tick closes a period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= 1'b0;
      else if (restart) phase_q <= 1'b0;
      else if (tick)    phase_q <= ~phase_q;
   end

   assign half_tick = tick;
   assign scl_en    = tick & phase_q;

   // R4: period strobe only together with a half tick
   a_r4_en_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
      scl_en |-> half_tick);

   // R4: two period strobes are never on consecutive half ticks
   a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_en && !restart) |=> !scl_en);

   // R6: disabled generator stays silent
   a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!half_tick && !scl_en));

   // R5: a restart drops any pending strobe
   a_r5_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !half_tick);

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b1;
   logic [2:0] rate_code = 3'b000;
   logic       ext_clk = 1'b0;
   logic       half_tick;
   logic       scl_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   // External clock: 100 ns period (10 system cycles), offset from clk edges.
   initial begin
      #3;
      forever #50 ext_clk = ~ext_clk;
   end

   scl_rate_gen u_scl_rate_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .rate_code (rate_code),
      .ext_clk   (ext_clk),
      .half_tick (half_tick),
      .scl_en    (scl_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Measure from the restart edge E0 (the next posedge): ticks at n*h cycles,
   // scl_en on even ticks, silence elsewhere.
   task automatic measure(input int h, input string req);
      int cyc = 0;
      int nt  = 0;
      @(posedge clk); #1;
      check(half_tick == 1'b0, {req, " R5 restart edge"}, half_tick, 0);
      while (nt < 4 && cyc < 4 * h + 10) begin
         @(posedge clk); #1;
         cyc++;
         if (half_tick) begin
            nt++;
            check(cyc == nt * h, req, cyc, nt * h);
            check(scl_en == (nt % 2 == 0), {req, " R4 scl_en"}, scl_en, nt % 2 == 0);
         end else if (scl_en) begin
            check(1'b0, {req, " R4 scl_en without tick"}, 1, 0);
         end
      end
      check(nt == 4, {req, " tick count"}, nt, 4);
   endtask

   task automatic set_code(input logic [2:0] c, input int h, input string req);
      @(negedge clk);
      rate_code = c;
      measure(h, req);
   endtask

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      check(half_tick == 1'b0 && scl_en == 1'b0, "R7 reset outputs", {half_tick, scl_en}, 0);
      rst_n = 1'b1;
      measure(128, "R7 after reset code 000");

      // R1, R2 sweep; ext_clk toggles throughout (R8)
      set_code(3'b001, 112, "R1 code 001");
      set_code(3'b010,  96, "R1 code 010");
      set_code(3'b011,  80, "R1 R8 code 011");
      set_code(3'b100, 480, "R2 code 100");
      set_code(3'b101,  60, "R2 code 101");
      set_code(3'b110,  30, "R2 R8 code 110");
      set_code(3'b000, 128, "R1 code 000");

      // R5: change mid-period, first tick is a full half period later
      repeat (50) @(negedge clk);
      set_code(3'b110, 30, "R5 mid-period change");

      // R6: disable
      @(negedge clk);
      enable = 1'b0;
      begin
         int seen = 0;
         for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            if (half_tick || scl_en) seen++;
         end
         check(seen == 0, "R6 silent while disabled", seen, 0);
      end
      @(negedge clk);
      enable = 1'b1;
      measure(30, "R6 re-enable restart");

      // R3: external mode
      @(negedge clk);
      rate_code = 3'b111;
      begin
         int cyc  = 0;
         int nt   = 0;
         int last = 0;
         while (nt < 6 && cyc < 400) begin
            @(posedge clk); #1;
            cyc++;
            if (half_tick) begin
               nt++;
               if (nt == 1)
                  check(cyc <= 45, "R3 first ext tick", cyc, 45);
               else
                  check(cyc - last == 40, "R3 ext tick spacing", cyc - last, 40);
               check(scl_en == (nt % 2 == 0), "R3 R4 ext scl_en", scl_en, nt % 2 == 0);
               last = cyc;
            end
         end
         check(nt == 6, "R3 ext tick count", nt, 6);
      end

      // Back to a system rate from external mode
      set_code(3'b101, 60, "R2 R5 leave ext mode");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule